// File: doc/BRIEF.md
# Prioritised Transmit Channel Scheduler

This block picks which transmit DMA channel the data mover serves next. Each channel has a pending input, driven high while its transmit queue holds work, and a two-bit priority. Among the eligible channels the highest priority level wins. Channels that share a level take turns. Once a channel is granted, the grant stays on it until its packet ends. A packet starts with a start-of-packet pulse and closes with an end-of-packet pulse from the data mover. A packet is never pre-empted.

Each channel also carries a small control state machine, driven by a single command port. A channel can be enabled, disabled at once even inside a packet, paused gracefully at the end of its packet, or torn down. A teardown raises a per-channel completion flag. The current state of every channel is visible on a status bus.

Top module: `tx_chan_sched`

## Requirements
- R1: After reset every channel is IDLE (status code 0), every teardown-done flag is low and `grant_valid` is low.
- R2: A channel is eligible only while its `qpend` bit is high and its state is ACTIVE (code 1). An enable command (op 0) moves a channel from IDLE, PAUSED (3) or DISABLED (5) to ACTIVE.
- R3: When no grant is held, the next clock edge grants an eligible channel at the numerically highest priority level. Channel c's priority is `chan_prio[2c+1:2c]`, and 3 is the highest.
- R4: Within one level, the search starts at the slot after the channel last granted at that level, wrapping from N-1 to 0. Every level's pointer starts at 0.
- R5: A grant stays on the same channel from the edge that issues it until it is released. Other requests cannot move it, even from a higher level or after the granted channel's `qpend` falls.
- R6: `pkt_eop` while a packet is in progress (after `pkt_sop` of the current grant) releases the grant on that edge. A new grant can follow on the next edge.
- R7: A disable command (op 1) puts the channel in DISABLED on the next edge. If it holds the grant, the grant drops on that same edge, even mid-packet.
- R8: A pause command (op 2) on an ACTIVE channel goes straight to PAUSED if no packet is in progress on it. This also releases a grant issued before its `pkt_sop`. Mid-packet it goes to PAUSING (2), keeps the grant, and moves to PAUSED when the packet ends.
- R9: A teardown command (op 3) on an ACTIVE, PAUSING or PAUSED channel goes straight to IDLE with its done flag set if no packet is in progress. Mid-packet it goes to TEARDOWN (4) and reaches IDLE with the flag set when the packet ends.
- R10: The teardown-done flag is cleared by an enable or disable command to that channel.
- R11: A channel named by a command cannot be granted in that same cycle. A pause arriving together with the channel's `pkt_eop` leaves it PAUSED with the grant released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qpend | input | N | Per-channel queue-pending requests |
| chan_prio | input | 2*N | Per-channel priority, 2 bits each |
| cmd_valid | input | 1 | Control command strobe |
| cmd_chan | input | log2(N) | Channel the command targets |
| cmd_op | input | 2 | 0 enable, 1 disable, 2 pause, 3 teardown |
| pkt_sop | input | 1 | Start of packet on the granted channel |
| pkt_eop | input | 1 | End of packet on the granted channel |
| grant_valid | output | 1 | A channel holds the grant |
| grant_chan | output | log2(N) | Number of the granted channel |
| chan_state | output | 3*N | Per-channel state code, 3 bits each |
| td_done | output | N | Per-channel teardown-done flags |

## Verification
Two functions can land on one edge: the end of a packet and a control command aimed at the channel sending that packet. The bench provokes this by driving `pkt_eop` and a pause command for the granted channel in the same cycle. It then checks that the channel reads PAUSED and that the grant is gone, rather than PAUSING with the grant still held. It also puts a command and a fresh request for an idle channel in the same cycle, and checks that no grant appears while the command takes effect.

// File: rtl/txsched_pkg.sv
package txsched_pkg;
  typedef enum logic [2:0] {
    CH_IDLE     = 3'd0,
    CH_ACTIVE   = 3'd1,
    CH_PAUSING  = 3'd2,
    CH_PAUSED   = 3'd3,
    CH_TEARDOWN = 3'd4,
    CH_DISABLED = 3'd5
  } ch_state_e;

  typedef enum logic [1:0] {
    OP_ENABLE   = 2'd0,
    OP_DISABLE  = 2'd1,
    OP_PAUSE    = 2'd2,
    OP_TEARDOWN = 2'd3
  } ch_op_e;
endpackage

// File: rtl/txsched_chan_ctrl.sv
module txsched_chan_ctrl
  import txsched_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_hit,
  input  ch_op_e    cmd_op,
  input  logic      in_pkt,
  input  logic      pkt_eop,
  output ch_state_e state,
  output logic      td_done
);
  ch_state_e state_q, state_d;
  logic      done_q, done_d, upd;
  logic      eop_here, mid_pkt;

  assign eop_here = in_pkt & pkt_eop;
  assign mid_pkt  = in_pkt & ~pkt_eop;

  always_comb begin
    state_d = state_q;
    done_d  = done_q;
    // packet end completes a pending pause or teardown
    if (eop_here && state_q == CH_PAUSING) state_d = CH_PAUSED;
    if (eop_here && state_q == CH_TEARDOWN) begin
      state_d = CH_IDLE;
      done_d  = 1'b1;
    end
    if (cmd_hit) begin
      case (cmd_op)
        OP_ENABLE: if (state_q inside {CH_IDLE, CH_PAUSED, CH_DISABLED}) begin
          state_d = CH_ACTIVE;
          done_d  = 1'b0;
        end
        OP_DISABLE: begin
          state_d = CH_DISABLED;
          done_d  = 1'b0;
        end
        OP_PAUSE: if (state_q == CH_ACTIVE)
          state_d = mid_pkt ? CH_PAUSING : CH_PAUSED;
        default: if (state_q inside {CH_ACTIVE, CH_PAUSING, CH_PAUSED}) begin
          if (mid_pkt) state_d = CH_TEARDOWN;
          else begin
            state_d = CH_IDLE;
            done_d  = 1'b1;
          end
        end
      endcase
    end
  end

  assign upd = (state_d != state_q) | (done_d != done_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      done_q  <= 1'b0;
    end else if (upd) begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign state   = state_q;
  assign td_done = done_q;

  // done flag is only ever seen on an idle channel
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    td_done |-> (state_q == CH_IDLE));
  // waiting states exist only while a packet is in progress
  p_wait_in_pkt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_PAUSING || state_q == CH_TEARDOWN) |-> in_pkt);
endmodule

// File: rtl/txsched_rr_pick.sv
module txsched_rr_pick #(
  parameter int N    = 8,
  parameter int LVLS = 4,
  localparam int IW  = $clog2(N),
  localparam int PW  = $clog2(LVLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     elig,
  input  logic [N*PW-1:0]  prio,
  input  logic [LVLS*IW-1:0] ptr,
  output logic             any,
  output logic [IW-1:0]    winner,
  output logic [PW-1:0]    lvl
);
  always_comb begin
    logic          hit;
    logic [IW-1:0] pick;
    int            idx;
    any    = 1'b0;
    winner = '0;
    lvl    = '0;
    for (int l = 0; l < LVLS; l++) begin
      hit  = 1'b0;
      pick = '0;
      for (int k = 0; k < N; k++) begin
        idx = (int'(ptr[l*IW +: IW]) + k) % N;
        if (!hit && elig[idx] && prio[idx*PW +: PW] == PW'(l)) begin
          hit  = 1'b1;
          pick = IW'(idx);
        end
      end
      if (hit) begin
        any    = 1'b1;
        winner = pick;
        lvl    = PW'(l);
      end
    end
  end

  logic [N-1:0] above;
  always_comb begin
    for (int c = 0; c < N; c++)
      above[c] = elig[c] && (prio[c*PW +: PW] > lvl);
  end

  p_pick_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> elig[winner]);
  p_pick_top_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (above == '0));
endmodule

// File: rtl/tx_chan_sched.sv
module tx_chan_sched
  import txsched_pkg::*;
#(
  parameter int N    = 8,
  parameter int LVLS = 4,
  localparam int IW  = $clog2(N),
  localparam int PW  = $clog2(LVLS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    qpend,
  input  logic [N*PW-1:0] chan_prio,
  input  logic            cmd_valid,
  input  logic [IW-1:0]   cmd_chan,
  input  logic [1:0]      cmd_op,
  input  logic            pkt_sop,
  input  logic            pkt_eop,
  output logic            grant_valid,
  output logic [IW-1:0]   grant_chan,
  output logic [N*3-1:0]  chan_state,
  output logic [N-1:0]    td_done
);
  ch_op_e          op;
  ch_state_e       st [N];
  logic [N-1:0]    elig, cmd_hit;
  logic            busy_q, busy_d, inpk_q, inpk_d;
  logic [IW-1:0]   gch_q, gch_d;
  logic [LVLS*IW-1:0] ptr_q, ptr_d;
  logic            any, release_g, own_hit, upd;
  logic [IW-1:0]   winner;
  logic [PW-1:0]   lvl;

  assign op = ch_op_e'(cmd_op);

  for (genvar c = 0; c < N; c++) begin : g_ch
    logic owned;
    assign cmd_hit[c] = cmd_valid && (cmd_chan == IW'(c));
    assign owned      = busy_q && (gch_q == IW'(c));
    txsched_chan_ctrl u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_hit (cmd_hit[c]),
      .cmd_op  (op),
      .in_pkt  (owned && inpk_q),
      .pkt_eop (pkt_eop),
      .state   (st[c]),
      .td_done (td_done[c])
    );
    assign elig[c] = qpend[c] && (st[c] == CH_ACTIVE) && !cmd_hit[c];
    assign chan_state[c*3 +: 3] = st[c];
  end

  txsched_rr_pick #(.N(N), .LVLS(LVLS)) u_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .elig   (elig),
    .prio   (chan_prio),
    .ptr    (ptr_q),
    .any    (any),
    .winner (winner),
    .lvl    (lvl)
  );

  assign own_hit   = cmd_valid && (cmd_chan == gch_q);
  assign release_g = (inpk_q && pkt_eop) ||
                     (own_hit && (op == OP_DISABLE ||
                      (!inpk_q && (op == OP_PAUSE || op == OP_TEARDOWN))));

  always_comb begin
    busy_d = busy_q;
    inpk_d = inpk_q;
    gch_d  = gch_q;
    ptr_d  = ptr_q;
    if (busy_q) begin
      if (release_g) begin
        busy_d = 1'b0;
        inpk_d = 1'b0;
      end else if (pkt_sop) begin
        inpk_d = 1'b1;
      end
    end else if (any) begin
      busy_d = 1'b1;
      gch_d  = winner;
      ptr_d[lvl*IW +: IW] = (int'(winner) == N-1) ? '0 : winner + 1'b1;
    end
  end

  assign upd = (busy_d != busy_q) | (inpk_d != inpk_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      inpk_q <= 1'b0;
      gch_q  <= '0;
      ptr_q  <= '0;
    end else if (upd) begin
      busy_q <= busy_d;
      inpk_q <= inpk_d;
      gch_q  <= gch_d;
      ptr_q  <= ptr_d;
    end
  end

  assign grant_valid = busy_q;
  assign grant_chan  = gch_q;

  p_owner_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (st[grant_chan] inside {CH_ACTIVE, CH_PAUSING, CH_TEARDOWN}));
  p_grant_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && $past(grant_valid)) |-> $stable(grant_chan));
  p_eop_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && inpk_q && pkt_eop) |=> !grant_valid);
  p_disable_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && cmd_valid && op == OP_DISABLE && cmd_chan == grant_chan)
      |=> (!grant_valid && st[$past(grant_chan)] == CH_DISABLED));
endmodule

// File: tb/tb_tx_chan_sched.sv
module tb_tx_chan_sched;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [7:0]   qpend;
  logic [15:0]  chan_prio;
  logic         cmd_valid;
  logic [2:0]   cmd_chan;
  logic [1:0]   cmd_op;
  logic         pkt_sop, pkt_eop;
  logic         grant_valid;
  logic [2:0]   grant_chan;
  logic [23:0]  chan_state;
  logic [7:0]   td_done;

  int tests = 0;
  int fails = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  tx_chan_sched #(.N(N), .LVLS(4)) dut (
    .clk(clk), .rst_n(rst_n), .qpend(qpend), .chan_prio(chan_prio),
    .cmd_valid(cmd_valid), .cmd_chan(cmd_chan), .cmd_op(cmd_op),
    .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .grant_valid(grant_valid),
    .grant_chan(grant_chan), .chan_state(chan_state), .td_done(td_done)
  );

  typedef struct packed {
    logic [7:0] q;
    logic       sop;
    logic       eop;
    logic       gv;
    logic [2:0] gc;
  } vec_t;

  // ch0-3 level 1, ch4-5 level 2, ch6-7 level 0; requirements R3 R4 R5 R6
  localparam vec_t VEC [25] = '{
    '{8'h0F,1'b0,1'b0,1'b1,3'd0}, '{8'h0F,1'b1,1'b0,1'b1,3'd0}, '{8'h0F,1'b0,1'b1,1'b0,3'd0},
    '{8'h0F,1'b0,1'b0,1'b1,3'd1}, '{8'h0F,1'b1,1'b0,1'b1,3'd1}, '{8'h0F,1'b0,1'b1,1'b0,3'd0},
    '{8'h3F,1'b0,1'b0,1'b1,3'd4}, '{8'h0F,1'b1,1'b0,1'b1,3'd4}, '{8'h0F,1'b0,1'b1,1'b0,3'd0},
    '{8'h0F,1'b0,1'b0,1'b1,3'd2}, '{8'h0F,1'b1,1'b0,1'b1,3'd2}, '{8'h0F,1'b0,1'b1,1'b0,3'd0},
    '{8'h09,1'b0,1'b0,1'b1,3'd3}, '{8'h09,1'b1,1'b0,1'b1,3'd3}, '{8'h09,1'b0,1'b1,1'b0,3'd0},
    '{8'h09,1'b0,1'b0,1'b1,3'd0}, '{8'h09,1'b1,1'b0,1'b1,3'd0}, '{8'h09,1'b0,1'b1,1'b0,3'd0},
    '{8'h30,1'b0,1'b0,1'b1,3'd5}, '{8'h30,1'b1,1'b0,1'b1,3'd5}, '{8'h30,1'b0,1'b1,1'b0,3'd0},
    '{8'hC0,1'b0,1'b0,1'b1,3'd6}, '{8'hC0,1'b1,1'b0,1'b1,3'd6}, '{8'hC0,1'b0,1'b1,1'b0,3'd0},
    '{8'h00,1'b0,1'b0,1'b0,3'd0}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cmd(input int ch, input int op);
    cmd_valid = 1'b1;
    cmd_chan  = 3'(ch);
    cmd_op    = 2'(op);
    tick();
    cmd_valid = 1'b0;
  endtask

  function automatic int st(input int ch);
    return int'(chan_state[ch*3 +: 3]);
  endfunction

  task automatic chk_grant(input string req, input bit gv, input int gc);
    chk(grant_valid == gv, req, "grant_valid", int'(grant_valid), int'(gv));
    if (gv) chk(int'(grant_chan) == gc, req, "grant_chan", int'(grant_chan), gc);
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; qpend = '0; chan_prio = 16'h0A55;
    cmd_valid = 1'b0; cmd_chan = '0; cmd_op = '0; pkt_sop = 1'b0; pkt_eop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(grant_valid == 1'b0, "R1", "grant_valid", int'(grant_valid), 0);
    chk(chan_state == '0, "R1", "chan_state", int'(chan_state), 0);
    chk(td_done == '0, "R1", "td_done", int'(td_done), 0);
    // R2 idle channels are not eligible
    qpend = 8'hFF; tick();
    chk_grant("R2", 1'b0, 0);
    qpend = '0;
    for (int c = 0; c < N; c++) cmd(c, 0);
    chk(chan_state == 24'o11111111, "R2", "enabled states", int'(chan_state), 24'o11111111);

    // vector table: priority, rotation, hold, release
    foreach (VEC[i]) begin
      qpend = VEC[i].q; pkt_sop = VEC[i].sop; pkt_eop = VEC[i].eop;
      tick();
      chk_grant($sformatf("R3/R4/R5/R6 vec%0d", i), VEC[i].gv, int'(VEC[i].gc));
    end
    pkt_sop = 1'b0; pkt_eop = 1'b0;

    // R7 disable mid-packet
    qpend = 8'h01; tick(); chk_grant("R5", 1'b1, 0);
    pkt_sop = 1'b1; tick(); pkt_sop = 1'b0;
    cmd(0, 1);
    chk_grant("R7", 1'b0, 0);
    chk(st(0) == 5, "R7", "ch0 state", st(0), 5);
    tick(); chk_grant("R7 disabled not eligible", 1'b0, 0);
    qpend = '0; cmd(0, 0);
    chk(st(0) == 1, "R2", "ch0 re-enabled", st(0), 1);

    // R8 pause with no packet
    cmd(1, 2);
    chk(st(1) == 3, "R8", "ch1 paused", st(1), 3);
    qpend = 8'h02; tick(); chk_grant("R8 paused idle", 1'b0, 0);
    qpend = '0; cmd(1, 0);
    // R8 pause mid-packet
    qpend = 8'h02; tick(); chk_grant("R8", 1'b1, 1);
    pkt_sop = 1'b1; tick(); pkt_sop = 1'b0;
    cmd(1, 2);
    chk(st(1) == 2, "R8", "ch1 pausing", st(1), 2);
    chk_grant("R8 held", 1'b1, 1);
    qpend = '0; pkt_eop = 1'b1; tick(); pkt_eop = 1'b0;
    chk(st(1) == 3, "R8", "ch1 paused at eop", st(1), 3);
    chk_grant("R8 released", 1'b0, 0);

    // R9 teardown mid-packet
    cmd(1, 0);
    qpend = 8'h02; tick(); chk_grant("R9", 1'b1, 1);
    pkt_sop = 1'b1; tick(); pkt_sop = 1'b0; qpend = '0;
    cmd(1, 3);
    chk(st(1) == 4, "R9", "ch1 teardown", st(1), 4);
    chk(td_done[1] == 1'b0, "R9", "done early", int'(td_done[1]), 0);
    pkt_eop = 1'b1; tick(); pkt_eop = 1'b0;
    chk(st(1) == 0, "R9", "ch1 idle", st(1), 0);
    chk(td_done[1] == 1'b1, "R9", "done set", int'(td_done[1]), 1);
    cmd(1, 0);
    chk(td_done[1] == 1'b0, "R10", "done cleared by enable", int'(td_done[1]), 0);
    chk(st(1) == 1, "R10", "ch1 active", st(1), 1);
    // R9 teardown with no packet, R10 clear by disable
    cmd(2, 3);
    chk(st(2) == 0 && td_done[2], "R9", "ch2 idle+done", st(2) + 8*int'(td_done[2]), 8);
    cmd(2, 1);
    chk(st(2) == 5 && !td_done[2], "R10", "ch2 disabled, done clear",
        st(2) + 8*int'(td_done[2]), 5);

    // R11 pause on the eop cycle
    qpend = 8'h02; tick(); chk_grant("R11", 1'b1, 1);
    pkt_sop = 1'b1; tick(); pkt_sop = 1'b0; qpend = '0;
    pkt_eop = 1'b1; cmd(1, 2); pkt_eop = 1'b0;
    chk(st(1) == 3, "R11", "ch1 paused with eop", st(1), 3);
    chk_grant("R11 released", 1'b0, 0);
    // R11 command blocks a same-cycle grant
    qpend = 8'h08; cmd(3, 2);
    chk_grant("R11 no grant", 1'b0, 0);
    chk(st(3) == 3, "R11", "ch3 paused", st(3), 3);
    // R8 pause before sop releases the grant
    qpend = '0; cmd(3, 0);
    qpend = 8'h08; tick(); chk_grant("R8", 1'b1, 3);
    qpend = '0; cmd(3, 2);
    chk_grant("R8 pre-sop release", 1'b0, 0);
    chk(st(3) == 3, "R8", "ch3 paused pre-sop", st(3), 3);

    summary();
  end
endmodule